// File: doc/BRIEF.md
# TLB-Miss Exception Entry Unit

This block performs the hardware half of taking a TLB-miss exception in a 32-bit RISC core. When the translation lookup reports a miss, the unit captures the fault context in a single clock edge. It records the page number and the full faulting address. It records a cause code that separates loads from stores. It saves the return address, choosing the branch address when the faulting instruction sat in a delay slot, and it saves the old status word. It then produces the new status word, with privileged mode, exception blocking and the alternate register bank all switched on.

Alongside the capture, a replacement-way selector updates the 2-bit way pointer of a 4-way TLB. When every way of the indexed set is valid, the pointer steps by one and wraps from 3 back to 0. Otherwise the pointer takes the lowest-numbered invalid way. The unit also issues a one-cycle redirect pulse together with the handler fetch address, which is the vector base plus 0x400. A miss that arrives while exceptions are already blocked is refused: it raises an error pulse and changes no register.

Top module: `tlbmiss_entry`

## Requirements
- R1: After reset every register output, the way pointer `rc_o`, `redir_vld_o` and `err_o` are zero.
- R2: An accepted miss loads `tea_o` with `va_i`, and loads `pteh_o` with `{va_i[31:10], 2'b00, asid_i[7:0]}`.
- R3: An accepted miss loads `expevt_o` with 12'h040 when `is_store_i` is 0 (load) and with 12'h060 when it is 1 (store).
- R4: An accepted miss loads `spc_o` with `pc_i`, or with `br_pc_i` when `dslot_i` is 1.
- R5: An accepted miss loads `ssr_o` with `sr_i`, and loads `sr_o` with `sr_i` that has bits 30 (mode), 29 (bank) and 28 (block) forced to 1.
- R6: An accepted miss with `way_vld_i == 4'b1111` increments `rc_o` by 1, wrapping from 3 to 0.
- R7: An accepted miss with any way invalid loads `rc_o` with the index of the lowest-numbered clear bit of `way_vld_i`.
- R8: In the cycle after an accepted miss, `redir_vld_o` is 1 for exactly that cycle and `redir_pc_o` equals `vbr_i + 32'h400`.
- R9: A miss with `sr_i[28] == 1` is refused: `err_o` pulses in the next cycle, `redir_vld_o` stays 0, and no register output or `rc_o` changes.
- R10: Without `miss_i` no register output or `rc_o` changes, and `redir_vld_o` and `err_o` stay 0.

A miss is accepted when `miss_i` is 1 and `sr_i[28]` is 0. All captures happen at the clock edge that samples `miss_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | TLB miss strobe |
| va_i | input | 32 | Faulting virtual address |
| is_store_i | input | 1 | 1 = store access, 0 = load access |
| pc_i | input | 32 | PC of faulting instruction |
| dslot_i | input | 1 | Faulting instruction is in a delay slot |
| br_pc_i | input | 32 | PC of the related delayed branch |
| sr_i | input | 32 | Current status register |
| vbr_i | input | 32 | Vector base |
| asid_i | input | 8 | Current address-space identifier kept in PTEH |
| way_vld_i | input | 4 | Valid bits of the four ways of the indexed set |
| pteh_o | output | 32 | Captured page-table-entry-high word |
| tea_o | output | 32 | Captured faulting address |
| expevt_o | output | 12 | Captured exception code |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved status register |
| sr_o | output | 32 | Status word written on exception entry |
| rc_o | output | 2 | Replacement way pointer |
| redir_pc_o | output | 32 | Handler fetch address |
| redir_vld_o | output | 1 | One-cycle redirect pulse |
| err_o | output | 1 | Refused-miss pulse |

## Verification
The way selector is driven with all-valid sets, so that stepping and wrap from 3 to 0 show up, and with single, multiple and all-invalid patterns, which separate the lowest-index priority from any other order. Misses alternate between loads and stores and between delay-slot and normal faults, so that the cause code and the choice of return address are each seen in both states. Refused misses and idle cycles are mixed between accepted ones, which tells a real hold apart from a register that only happened to keep its value. Random addresses, status words and vector bases show that each field lands in the right bit positions.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  localparam int unsigned XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  localparam int unsigned SR_MD = 30;
  localparam int unsigned SR_RB = 29;
  localparam int unsigned SR_BL = 28;

  localparam logic [11:0] CODE_LOAD  = 12'h040;
  localparam logic [11:0] CODE_STORE = 12'h060;

  function automatic logic [11:0] miss_code(input logic store);
    return store ? CODE_STORE : CODE_LOAD;
  endfunction

  function automatic word_t sr_on_entry(input word_t s);
    word_t r;
    r = s;
    r[SR_MD] = 1'b1;
    r[SR_RB] = 1'b1;
    r[SR_BL] = 1'b1;
    return r;
  endfunction

  function automatic word_t return_pc(input word_t pc, input word_t br, input logic ds);
    return ds ? br : pc;
  endfunction
endpackage

// File: rtl/tlbm_way_sel.sv
module tlbm_way_sel #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned RC_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] way_vld_i,
  input  logic [RC_W-1:0] rc_i,
  output logic [RC_W-1:0] rc_next_o,
  output logic            all_vld_o
);
  always_comb begin
    all_vld_o = &way_vld_i;
    rc_next_o = rc_i + RC_W'(1);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld_i[w]) rc_next_o = RC_W'(w);
    end
  end
endmodule

// File: rtl/tlbm_capture.sv
module tlbm_capture
  import tlbm_pkg::*;
#(
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned VPN_LSB = 10,
  parameter int unsigned RC_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  word_t             va_i,
  input  logic              is_store_i,
  input  word_t             pc_i,
  input  logic              dslot_i,
  input  word_t             br_pc_i,
  input  word_t             sr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [RC_W-1:0]   rc_next_i,
  output word_t             pteh_o,
  output word_t             tea_o,
  output logic [11:0]       expevt_o,
  output word_t             spc_o,
  output word_t             ssr_o,
  output word_t             sr_o,
  output logic [RC_W-1:0]   rc_o
);
  localparam int unsigned GAP_W = VPN_LSB - ASID_W;

  function automatic word_t pteh_word(input word_t va, input logic [ASID_W-1:0] asid);
    return {va[XLEN-1:VPN_LSB], {GAP_W{1'b0}}, asid};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pteh_o   <= '0;
      tea_o    <= '0;
      expevt_o <= '0;
      spc_o    <= '0;
      ssr_o    <= '0;
      sr_o     <= '0;
      rc_o     <= '0;
    end else if (take_i) begin
      pteh_o   <= pteh_word(va_i, asid_i);
      tea_o    <= va_i;
      expevt_o <= miss_code(is_store_i);
      spc_o    <= return_pc(pc_i, br_pc_i, dslot_i);
      ssr_o    <= sr_i;
      sr_o     <= sr_on_entry(sr_i);
      rc_o     <= rc_next_i;
    end
  end
endmodule

// File: rtl/tlbmiss_entry.sv
module tlbmiss_entry
  import tlbm_pkg::*;
#(
  parameter int unsigned WAYS    = 4,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned VPN_LSB = 10,
  parameter logic [31:0] VEC_OFS = 32'h0000_0400,
  localparam int unsigned RC_W   = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_i,
  input  logic [31:0]       va_i,
  input  logic              is_store_i,
  input  logic [31:0]       pc_i,
  input  logic              dslot_i,
  input  logic [31:0]       br_pc_i,
  input  logic [31:0]       sr_i,
  input  logic [31:0]       vbr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [WAYS-1:0]   way_vld_i,
  output logic [31:0]       pteh_o,
  output logic [31:0]       tea_o,
  output logic [11:0]       expevt_o,
  output logic [31:0]       spc_o,
  output logic [31:0]       ssr_o,
  output logic [31:0]       sr_o,
  output logic [RC_W-1:0]   rc_o,
  output logic [31:0]       redir_pc_o,
  output logic              redir_vld_o,
  output logic              err_o
);
  logic            accept_w;
  logic            refuse_w;
  logic            all_vld_w;
  logic [RC_W-1:0] rc_next_w;

  assign accept_w = miss_i & ~sr_i[SR_BL];
  assign refuse_w = miss_i &  sr_i[SR_BL];

  tlbm_way_sel #(.WAYS(WAYS)) u_sel (
    .way_vld_i (way_vld_i),
    .rc_i      (rc_o),
    .rc_next_o (rc_next_w),
    .all_vld_o (all_vld_w)
  );

  tlbm_capture #(.ASID_W(ASID_W), .VPN_LSB(VPN_LSB), .RC_W(RC_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (accept_w),
    .va_i       (va_i),
    .is_store_i (is_store_i),
    .pc_i       (pc_i),
    .dslot_i    (dslot_i),
    .br_pc_i    (br_pc_i),
    .sr_i       (sr_i),
    .asid_i     (asid_i),
    .rc_next_i  (rc_next_w),
    .pteh_o     (pteh_o),
    .tea_o      (tea_o),
    .expevt_o   (expevt_o),
    .spc_o      (spc_o),
    .ssr_o      (ssr_o),
    .sr_o       (sr_o),
    .rc_o       (rc_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      redir_vld_o <= accept_w;
      err_o       <= refuse_w;
      if (accept_w) redir_pc_o <= vbr_i + VEC_OFS;
    end
  end
endmodule

// File: rtl/tlbm_chk.sv
module tlbm_chk #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned RC_W = $clog2(WAYS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept_w,
  input logic            refuse_w,
  input logic            all_vld_w,
  input logic            miss_i,
  input logic [WAYS-1:0] way_vld_i,
  input logic [RC_W-1:0] rc_o,
  input logic [31:0]     tea_o,
  input logic [31:0]     spc_o,
  input logic [31:0]     sr_o,
  input logic [11:0]     expevt_o,
  input logic            redir_vld_o,
  input logic            err_o
);
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> redir_vld_o && !err_o);

  p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_w |=> err_o && !redir_vld_o && $stable(tea_o) && $stable(spc_o) && $stable(rc_o));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_i |=> !redir_vld_o && !err_o && $stable(rc_o) && $stable(tea_o));

  p_sr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> sr_o[30] && sr_o[29] && sr_o[28]);

  p_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> (expevt_o == 12'h040 || expevt_o == 12'h060));

  p_rc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && all_vld_w) |=> rc_o == RC_W'($past(rc_o) + 1'b1));

  p_rc_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !all_vld_w) |=> (($past(way_vld_i) >> rc_o) & WAYS'(1)) == '0
      && ((~$past(way_vld_i)) & ((WAYS'(1) << rc_o) - WAYS'(1))) == '0);
endmodule

bind tlbmiss_entry tlbm_chk #(.WAYS(WAYS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept_w    (accept_w),
  .refuse_w    (refuse_w),
  .all_vld_w   (all_vld_w),
  .miss_i      (miss_i),
  .way_vld_i   (way_vld_i),
  .rc_o        (rc_o),
  .tea_o       (tea_o),
  .spc_o       (spc_o),
  .sr_o        (sr_o),
  .expevt_o    (expevt_o),
  .redir_vld_o (redir_vld_o),
  .err_o       (err_o)
);

// File: tb/test_tlbmiss_entry.sv
module test_tlbmiss_entry;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_i = 1'b0, is_store_i = 1'b0, dslot_i = 1'b0;
  logic [31:0] va_i = '0, pc_i = '0, br_pc_i = '0, sr_i = '0, vbr_i = '0;
  logic [7:0]  asid_i = '0;
  logic [3:0]  way_vld_i = '0;
  logic [31:0] pteh_o, tea_o, spc_o, ssr_o, sr_o, redir_pc_o;
  logic [11:0] expevt_o;
  logic [1:0]  rc_o;
  logic        redir_vld_o, err_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] e_pteh, e_tea, e_spc, e_ssr, e_sr, e_rpc;
  logic [11:0] e_code;
  logic [1:0]  e_rc;
  logic        e_vld, e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbmiss_entry i_tlbmiss_entry (.*);

  function automatic logic [1:0] bench_rc(input logic [3:0] v, input logic [1:0] cur);
    casez (v)
      4'b???0: return 2'd0;
      4'b??01: return 2'd1;
      4'b?011: return 2'd2;
      4'b0111: return 2'd3;
      default: return (cur == 2'd3) ? 2'd0 : cur + 2'd1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 pteh", pteh_o, e_pteh);
    chk("R2 tea", tea_o, e_tea);
    chk("R3 expevt", {20'd0, expevt_o}, {20'd0, e_code});
    chk("R4 spc", spc_o, e_spc);
    chk("R5 ssr", ssr_o, e_ssr);
    chk("R5 sr", sr_o, e_sr);
    chk("R6/R7 rc", {30'd0, rc_o}, {30'd0, e_rc});
    chk("R8 redir_vld", {31'd0, redir_vld_o}, {31'd0, e_vld});
    if (e_vld) chk("R8 redir_pc", redir_pc_o, e_rpc);
    chk("R9 err", {31'd0, err_o}, {31'd0, e_err});
  endtask

  task automatic step(input logic m, input logic [31:0] va, input logic st, input logic [31:0] pc,
                      input logic ds, input logic [31:0] br, input logic [31:0] sr,
                      input logic [31:0] vbr, input logic [7:0] asid, input logic [3:0] ways);
    miss_i = m; va_i = va; is_store_i = st; pc_i = pc; dslot_i = ds; br_pc_i = br;
    sr_i = sr; vbr_i = vbr; asid_i = asid; way_vld_i = ways;
    e_vld = 1'b0; e_err = 1'b0;
    if (m && sr[28]) e_err = 1'b1;
    else if (m) begin
      e_vld  = 1'b1;
      e_pteh = {va[31:10], 2'b00, asid};
      e_tea  = va;
      e_code = st ? 12'h060 : 12'h040;
      e_spc  = ds ? br : pc;
      e_ssr  = sr;
      e_sr   = sr | 32'h7000_0000;
      e_rc   = bench_rc(ways, e_rc);
      e_rpc  = vbr + 32'h400;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    e_pteh = '0; e_tea = '0; e_spc = '0; e_ssr = '0; e_sr = '0; e_rpc = '0;
    e_code = '0; e_rc = '0; e_vld = 0; e_err = 0;
    repeat (3) @(negedge clk);
    check_all(); // R1 reset state
    rst_n = 1'b1;
    // R10 idle, inputs wiggle without a miss
    step(0, 32'hdead_beef, 1, 32'h1111, 1, 32'h2222, 0, 32'h100, 8'h55, 4'b0000);
    // R7 all invalid -> 0; R3 load; R4 normal
    step(1, 32'h1234_5678, 0, 32'h8000_0010, 0, 32'h8000_000c, 32'h0000_00f0, 32'h8000_0000, 8'h3c, 4'b0000);
    // R7 pattern 1011 -> way 2; R3 store; R4 delay slot
    step(1, 32'hffff_fc00, 1, 32'h8000_0020, 1, 32'h8000_001c, 32'h4000_0001, 32'h0, 8'ha5, 4'b1011);
    // R7 pattern 0111 -> way 3
    step(1, 32'h0000_03ff, 0, 32'h4, 0, 32'h0, 32'h0, 32'hffff_fc00, 8'h01, 4'b0111);
    // R6 all valid: 3 wraps to 0, then steps to 1
    step(1, 32'h0abc_d000, 1, 32'h8, 0, 32'h0, 32'h0, 32'h10, 8'h02, 4'b1111);
    step(1, 32'h0abc_e000, 0, 32'hc, 0, 32'h0, 32'h0, 32'h10, 8'h02, 4'b1111);
    // R9 refused miss while blocked
    step(1, 32'h7777_7777, 1, 32'h99, 1, 32'h98, 32'h1000_0000, 32'h2000, 8'hff, 4'b0000);
    // R8 pulse ends after one cycle
    step(0, 32'h0, 0, 32'h0, 0, 32'h0, 32'h0, 32'h0, 8'h0, 4'b0000);
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] w;
      w = ($urandom % 2) ? 4'b1111 : 4'($urandom);
      step(($urandom % 4) != 0, $urandom, 1'($urandom), $urandom, 1'($urandom), $urandom,
           ($urandom % 4 == 0) ? ($urandom | 32'h1000_0000) : ($urandom & 32'hefff_ffff),
           $urandom, 8'($urandom), w);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule